// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block places a small direct-mapped data cache between a processor-side request port carrying 32-bit words and a main memory that moves one byte per transfer. Reads and writes that hit are served from on-chip storage with no memory traffic. A miss allocates the line for both reads and writes. If the line being replaced holds modified data, it is first copied back to memory. The new line is then fetched, and the request is replayed as a hit.

Both ports use a wait-request handshake. The processor holds its address, strobe and write data steady until the controller drops `cpu_wait` for one cycle. On the memory side, each strobe stays asserted with a steady address and data until a clock edge at which `mem_wait` is low. A line is four words and moves as sixteen byte transfers in ascending address order.

Top module: `dm_wb_cache`

## Requirements
- R1: After a synchronous reset, `cpu_wait` is 1, `mem_rd` and `mem_wr` are 0, and every line is invalid, so the first access to any address misses.
- R2: Only address bits [14:9] (tag), [8:4] (line index) and [3:2] (word in line) matter. Bits [31:15] and [1:0] have no effect on the outcome.
- R3: A read whose tag matches a valid line returns the stored word and causes no memory transfer.
- R4: A write whose tag matches a valid line replaces the addressed word, marks the line modified and causes no memory transfer. A later read returns the new word.
- R5: A miss on an invalid line or an unmodified line causes no memory write. It performs exactly 16 byte reads at base, base+1, ..., base+15, where base is the request address bits [14:4] followed by four zero bits.
- R6: A miss on a valid modified line first performs 16 byte writes of the old line, in ascending order, at addresses formed from the old tag and the index. After those writes come the 16 refill reads of R5.
- R7: Byte j of word k in a line sits at memory address base + 4k + j and occupies bits [8j+7:8j] of the word (little-endian). This holds for both refill and write-back.
- R8: A refilled line is valid and unmodified and carries the new tag. If it is evicted before any write, no write-back takes place.
- R9: A write miss allocates the line as in R5/R6 and then merges the write data as a write hit. The merged line is written back on its next eviction.
- R10: A memory strobe stays asserted with a stable address (and, for writes, stable data) while `mem_wait` is high. `mem_rd` and `mem_wr` are never high together.
- R11: A request with both `cpu_rd` and `cpu_wr` high is ignored. It causes no memory transfer, `cpu_wait` does not drop, and the cache contents are unchanged.
- R12: Each accepted request ends with `cpu_wait` low for exactly one cycle. Read data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_wait` is low |
| cpu_wait | output | 1 | High until the current request completes |
| mem_addr | output | 15 | Memory byte address |
| mem_rd | output | 1 | Memory byte read strobe |
| mem_wr | output | 1 | Memory byte write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_wait | input | 1 | Memory wait request; a transfer completes on an edge where it is low |

## Verification
Some internal faults show at the ports only later. A wrong valid, modified or tag bit produces no symptom until the next access to that line index. It then appears as a missing or unexpected burst of sixteen memory transfers, or as a write-back to the wrong address. A byte placed in the wrong lane during refill corrupts the very next read that returns data. A lane error in write-back appears only after the line has been evicted and fetched again. Stale modified data therefore surfaces at least two misses after the fault. For this reason every line index is driven through clean misses, hits, modified evictions and refetches, with varied memory wait times.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for a single-strobe request
    ST_LOOK,   // tag compare, word read available
    ST_RERD,   // re-read of the word after a refill
    ST_WB_LD,  // present write-back word to the data RAM
    ST_WB_GO,  // launch one write-back byte
    ST_WB_WT,  // wait for the write-back byte to be taken
    ST_FL_GO,  // launch one refill byte
    ST_FL_WT,  // wait for the refill byte
    ST_RESP    // one-cycle completion to the processor
  } dmc_state_e;

endpackage

// File: rtl/dmc_word_ram.sv
module dmc_word_ram #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // single port, read-first: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
    rdata <= mem_q[addr];
  end

endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 5,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // per-line status bits, cleared by reset
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= 1'b0;
      end else if (mark_en && mark_idx == IDX_W'(g)) begin
        dirty_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // R4: only a line already holding data may become modified
  a_r4_mark_valid: assert property (@(posedge clk) disable iff (rst)
    mark_en |-> valid_q[mark_idx]);

  // R8: a refill and a modify never target one line in the same cycle
  a_r8_fill_mark_apart: assert property (@(posedge clk) disable iff (rst)
    (fill_en && mark_en) |-> (fill_idx != mark_idx));

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int CPU_AW = 32,
  parameter int DW     = 32,
  parameter int BYTE_W = 8,
  parameter int TAG_W  = 6,
  parameter int IDX_W  = 5,
  parameter int WSEL_W = 2,
  parameter int MEM_AW = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_wait,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_wait
);
  localparam int BPW     = DW / BYTE_W;
  localparam int BOFF_W  = $clog2(BPW);
  localparam int IDX_LSB = BOFF_W + WSEL_W;
  localparam int TAG_LSB = IDX_LSB + IDX_W;
  localparam int RAM_AW  = IDX_W + WSEL_W;

  dmc_state_e state;

  logic              req_wr;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic [DW-1:0]     req_wdata;
  logic [WSEL_W-1:0] wcnt;
  logic [BOFF_W-1:0] bcnt;
  logic [DW-1:0]     asm_buf, asm_next;

  logic              line_valid, line_dirty, hit;
  logic [TAG_W-1:0]  line_tag;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we;
  logic [DW-1:0]     ram_wdata, ram_rdata;
  logic              fill_en, mark_en;
  logic              last_b, last_w, mem_done;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{cpu_addr[CPU_AW-1:TAG_LSB+TAG_W], cpu_addr[BOFF_W-1:0]};

  assign hit      = line_valid && (line_tag == req_tag);
  assign last_b   = (bcnt == {BOFF_W{1'b1}});
  assign last_w   = (wcnt == {WSEL_W{1'b1}});
  assign mem_done = !mem_wait;

  // place the arriving byte in its little-endian lane
  always_comb begin
    asm_next = asm_buf;
    asm_next[int'(bcnt)*BYTE_W +: BYTE_W] = mem_rdata;
  end

  always_comb begin
    case (state)
      ST_IDLE:                                ram_addr = {cpu_addr[IDX_LSB +: IDX_W], cpu_addr[BOFF_W +: WSEL_W]};
      ST_WB_LD, ST_WB_GO, ST_WB_WT, ST_FL_WT: ram_addr = {req_idx, wcnt};
      default:                                ram_addr = {req_idx, req_word};
    endcase
  end

  always_comb begin
    ram_we    = 1'b0;
    ram_wdata = req_wdata;
    if (state == ST_LOOK && hit && req_wr) begin
      ram_we = 1'b1;
    end else if (state == ST_FL_WT && mem_done && last_b) begin
      ram_we    = 1'b1;
      ram_wdata = asm_next;
    end
  end

  assign mark_en = (state == ST_LOOK) && hit && req_wr;
  assign fill_en = (state == ST_FL_WT) && mem_done && last_b && last_w;

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .rd_valid (line_valid),
    .rd_dirty (line_dirty),
    .rd_tag   (line_tag),
    .fill_en  (fill_en),
    .fill_idx (req_idx),
    .fill_tag (req_tag),
    .mark_en  (mark_en),
    .mark_idx (req_idx)
  );

  dmc_word_ram #(.AW(RAM_AW), .DW(DW)) u_data (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_wait  <= 1'b1;
      cpu_rdata <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      req_wr    <= 1'b0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_word  <= '0;
      req_wdata <= '0;
      wcnt      <= '0;
      bcnt      <= '0;
      asm_buf   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cpu_rd ^ cpu_wr) begin
            req_wr    <= cpu_wr;
            req_tag   <= cpu_addr[TAG_LSB +: TAG_W];
            req_idx   <= cpu_addr[IDX_LSB +: IDX_W];
            req_word  <= cpu_addr[BOFF_W +: WSEL_W];
            req_wdata <= cpu_wdata;
            state     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            if (!req_wr) cpu_rdata <= ram_rdata;
            cpu_wait <= 1'b0;
            state    <= ST_RESP;
          end else begin
            wcnt  <= '0;
            bcnt  <= '0;
            state <= (line_valid && line_dirty) ? ST_WB_LD : ST_FL_GO;
          end
        end
        ST_RERD:  state <= ST_LOOK;
        ST_WB_LD: state <= ST_WB_GO;
        ST_WB_GO: begin
          mem_wr    <= 1'b1;
          mem_addr  <= {line_tag, req_idx, wcnt, bcnt};
          mem_wdata <= ram_rdata[int'(bcnt)*BYTE_W +: BYTE_W];
          state     <= ST_WB_WT;
        end
        ST_WB_WT: begin
          if (mem_done) begin
            mem_wr <= 1'b0;
            bcnt   <= bcnt + 1'b1;
            if (last_b) begin
              wcnt  <= wcnt + 1'b1;
              state <= last_w ? ST_FL_GO : ST_WB_LD;
            end else begin
              state <= ST_WB_GO;
            end
          end
        end
        ST_FL_GO: begin
          mem_rd   <= 1'b1;
          mem_addr <= {req_tag, req_idx, wcnt, bcnt};
          state    <= ST_FL_WT;
        end
        ST_FL_WT: begin
          if (mem_done) begin
            mem_rd  <= 1'b0;
            asm_buf <= asm_next;
            bcnt    <= bcnt + 1'b1;
            if (last_b) begin
              wcnt  <= wcnt + 1'b1;
              state <= last_w ? ST_RERD : ST_FL_GO;
            end else begin
              state <= ST_FL_GO;
            end
          end
        end
        ST_RESP: begin
          cpu_wait <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: strobes are exclusive and held steady while memory stalls
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_wait) |=> (mem_rd && $stable(mem_addr)));
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_wait) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  // R12: completion lasts one cycle
  a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !cpu_wait |=> cpu_wait);

  // R6: memory writes only ever empty a valid modified line
  a_r6_wb_dirty_only: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (line_valid && line_dirty));

  // R5: refill reads always use the requested tag and index
  a_r5_fill_addr: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr[MEM_AW-1 -: TAG_W+IDX_W] == {req_tag, req_idx}));

  // R3: completion never coincides with memory traffic
  a_r3_quiet_done: assert property (@(posedge clk) disable iff (rst)
    !cpu_wait |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/sim_dm_wb_cache.sv
module sim_dm_wb_cache;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_wait;
  logic [14:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_wait;

  always #10 clk = ~clk;  // 50 MHz

  dm_wb_cache u0 (
    .clk(clk), .rst(rst),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_wait(mem_wait)
  );

  int total = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  // ---------------- memory model ----------------
  logic [7:0] wmem [int];

  function automatic logic [7:0] initb(int a);
    return 8'((a * 29) + (a >> 5) + 7);
  endfunction

  function automatic logic [7:0] memb(int a);
    if (wmem.exists(a)) return wmem[a];
    return initb(a);
  endfunction

  int lcnt = 0;
  int lat;
  assign lat       = (int'(mem_addr[1:0]) + int'(mem_addr[4])) % 3;
  assign mem_wait  = (mem_rd | mem_wr) && (lcnt <= lat);
  assign mem_rdata = memb(int'(mem_addr));

  int          lg_addr [$];
  bit          lg_wr   [$];
  logic [7:0]  lg_data [$];

  // the transfer completes at the coming edge once the count passes lat
  always @(negedge clk) begin
    if (mem_rd | mem_wr) begin
      lcnt = lcnt + 1;
      if (lcnt == lat + 1) begin
        lg_addr.push_back(int'(mem_addr));
        lg_wr.push_back(mem_wr);
        lg_data.push_back(mem_wdata);
        if (mem_wr) wmem[int'(mem_addr)] = mem_wdata;
      end
    end else begin
      lcnt = 0;
    end
  end

  // ---------------- reference cache model ----------------
  bit          mv [32];
  bit          md [32];
  int          mt [32];
  logic [31:0] refw [int];

  function automatic logic [31:0] refget(int wa);
    if (refw.exists(wa)) return refw[wa];
    return {initb(wa*4+3), initb(wa*4+2), initb(wa*4+1), initb(wa*4)};
  endfunction

  function automatic logic [31:0] mk(int tg, int idx, int w);
    return {17'd0, 6'(tg), 5'(idx), 2'(w), 2'b00};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(logic [31:0] a, bit wr, logic [31:0] wd, string req);
    int          idx = int'(a[8:4]);
    int          tg  = int'(a[14:9]);
    int          wa  = int'(a[14:2]);
    bit          hit = mv[idx] && (mt[idx] == tg);
    int          ea [$];
    bit          ew [$];
    logic [7:0]  ed [$];
    int          n;
    bit          ok;
    if (!hit) begin
      if (mv[idx] && md[idx]) begin
        for (int k = 0; k < 4; k++)
          for (int j = 0; j < 4; j++) begin
            logic [31:0] ow = refget((mt[idx] << 7) | (idx << 2) | k);
            ea.push_back((mt[idx] << 9) | (idx << 4) | (k << 2) | j);
            ew.push_back(1'b1);
            ed.push_back(ow[j*8 +: 8]);
          end
      end
      for (int k = 0; k < 4; k++)
        for (int j = 0; j < 4; j++) begin
          ea.push_back((tg << 9) | (idx << 4) | (k << 2) | j);
          ew.push_back(1'b0);
          ed.push_back(8'h00);
        end
    end
    lg_addr.delete(); lg_wr.delete(); lg_data.delete();
    cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = wd;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cpu_wait && n < 3000);
    chk(!cpu_wait, {req, " R12 completion"}, 32'(cpu_wait), 32'd0);
    if (!wr) chk(cpu_rdata === refget(wa), {req, " R7 read data"}, cpu_rdata, refget(wa));
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    ok = (lg_addr.size() == ea.size());
    for (int i = 0; ok && i < ea.size(); i++)
      if (lg_addr[i] != ea[i] || lg_wr[i] != ew[i] || (ew[i] && lg_data[i] !== ed[i])) begin
        ok = 1'b0;
        chk(1'b0, {req, " R10 transfer"}, {lg_wr[i], lg_data[i], 8'd0, 15'(lg_addr[i])},
            {ew[i], ed[i], 8'd0, 15'(ea[i])});
      end
    if (lg_addr.size() != ea.size())
      chk(1'b0, {req, " R10 transfer count"}, 32'(lg_addr.size()), 32'(ea.size()));
    else if (ok)
      chk(1'b1, req, 0, 0);
    @(negedge clk);
    chk(cpu_wait === 1'b1, {req, " R12 one-cycle"}, 32'(cpu_wait), 32'd1);
    // model update
    if (!hit) begin mv[idx] = 1'b1; md[idx] = 1'b0; mt[idx] = tg; end
    if (wr) begin md[idx] = 1'b1; refw[wa] = wd; end
  endtask

  initial begin
    #(20ns * 150000);
    if (!done_flag) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(cpu_wait === 1'b1, "R1 cpu_wait in reset", 32'(cpu_wait), 32'd1);
    chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R1 mem strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_wait === 1'b1 && mem_rd === 1'b0, "R1 idle after reset", 32'(cpu_wait), 32'd1);

    // R1 R5 R7: every line starts invalid, clean refills
    for (int i = 0; i < 32; i++) do_req(mk(0, i, i % 4), 1'b0, 0, "R1/R5 cold read miss");
    // R3: read hits on every word
    for (int i = 0; i < 32; i++)
      for (int w = 0; w < 4; w++) do_req(mk(0, i, w), 1'b0, 0, "R3 read hit");
    // R4: write hits, then read back
    for (int i = 0; i < 32; i++) do_req(mk(0, i, (i + 1) % 4), 1'b1, 32'hA5C30000 ^ (i * 32'h01030507), "R4 write hit");
    for (int i = 0; i < 32; i++) do_req(mk(0, i, (i + 1) % 4), 1'b0, 0, "R4 read back");
    // R2 R6 R9: write miss on modified lines, with junk upper and low bits
    for (int i = 0; i < 32; i++)
      do_req(32'hFFFF8003 | mk(1, i, i % 4), 1'b1, 32'h5A000000 + i * 32'h00010203, "R2/R6/R9 write miss");
    for (int i = 0; i < 32; i += 5) do_req(32'h12340001 | mk(1, i, i % 4), 1'b0, 0, "R2/R9 merged read");
    // R6 R8 R7: evict merged lines, then refetch (clean eviction, no write-back)
    for (int i = 0; i < 32; i++) begin
      do_req(mk(2, i, 3 - (i % 4)), 1'b0, 0, "R6 dirty eviction");
      do_req(mk(1, i, i % 4), 1'b0, 0, "R8/R7 clean refetch");
    end
    // R11: both strobes together are ignored
    lg_addr.delete();
    cpu_addr = mk(5, 3, 1); cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 32'hDEADBEEF;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk(cpu_wait === 1'b1, "R11 no completion", 32'(cpu_wait), 32'd1);
    end
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
    chk(lg_addr.size() == 0, "R11 no memory traffic", 32'(lg_addr.size()), 32'd0);
    do_req(mk(1, 3, 3), 1'b0, 0, "R11 line unchanged");
    do_req(mk(1, 3, 1), 1'b0, 0, "R11 line unchanged");

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule